// File: doc/BRIEF.md
# Learning DRAM Command Selector

This block picks one DRAM command per scheduling step. It does not use a fixed priority order. It keeps a table of learned value estimates, one for each pair of system state and candidate command, and issues the legal command whose estimate is highest. The system state is built from three queue occupancy counts: queued reads, queued writes and queued load misses. Each count is squeezed into a 2-bit level, so the three levels together name one of 64 states. Which commands are legal is decided outside the block, by the DRAM timing checker, and arrives as a per-command mask. The block never overrides that mask.

Learning happens online. A step that issues a column command (a write or either kind of read) earns a reward of 1.0. Every other step earns 0. Each step updates the estimate of the previous step's pair toward the reward plus a discounted copy of the estimate of the pair chosen now. Over time the table favours commands that keep the data bus busy. A 16-bit LFSR sometimes replaces the greedy pick with a random legal command, so that commands the table currently ranks low are still tried. Any table entry can be read at any time through a side read port.

Top module: `dram_qsel`

## Requirements
- R1: After reset every table entry reads 0, and the LFSR holds 16'hACE1.
- R2: Each count is mapped to a level: 0 for a count of 0, 1 for 1..3, 2 for 4..7, and 3 for 8 or more. The state index is rd_level*16 + wr_level*4 + lm_level.
- R3: On a step that does not explore, act_o is the legal command with the highest signed estimate in the current state. A tie goes to the lowest command index. The command codes are 0 activate, 1 write, 2 read for a load miss, 3 read for a store miss, 4 precharge for a pending request, 5 preemptive precharge, 6 NOP.
- R4: A command whose bit in legal_mask is 0 is never chosen. NOP is always legal, whatever legal_mask[6] holds, so a mask with bits 5..0 all clear gives act_o = 6.
- R5: The reward for a step is 256 (1.0 with 8 fraction bits) when the chosen command is 1, 2 or 3, and 0 for any other command.
- R6: At every enabled step after the first, the entry for the previous step's (state, command) becomes Qp + ((r + (Qc >>> 1) - Qp) >>> 2). Here Qp is that entry's old value, r is the previous step's reward, Qc is the estimate of the pair chosen in this step read before the write, and >>> is a flooring arithmetic shift. The first enabled step after reset writes nothing.
- R7: The LFSR shifts left once per enabled step, taking in the new bit lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]. When lfsr[3:0] is 0, the step explores: explored_o is 1, and act_o is the first legal command found by scanning upward, wrapping modulo 7, from index lfsr[15:4] % 7.
- R8: While step_en is 0, no table entry changes and the LFSR does not advance.
- R9: peek_val shows, combinationally, the table entry addressed by peek_state and peek_act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Scheduling step: commit the pick and learn |
| rd_cnt | input | 5 | Queued read count |
| wr_cnt | input | 5 | Queued write count |
| lm_cnt | input | 5 | Queued load-miss count |
| legal_mask | input | 7 | Per-command legality from the timing checker |
| act_o | output | 3 | Chosen command code |
| explored_o | output | 1 | The pick came from exploration |
| peek_state | input | 6 | Table read state index |
| peek_act | input | 3 | Table read command index |
| peek_val | output | 16 | Table entry, signed fixed point with 8 fraction bits |

## Verification
The bench's reference model tracks the table, the LFSR and the previous pair on every clock. It is stressed with masks that differ in every step, so a picker that ignored the mask or broke ties toward the high index would issue a command the model rejects. Steps in which the current pair is the same as the previous one expose an update that reads the value after its own write: the learned value would drift away from the model. Gaps in step_en catch an LFSR or table that keeps moving while idle, because the exploration decisions that follow would go out of step. Count values at the edges of the level bands (0, 1, 3, 4, 7, 8, 31) would land a mis-quantized state in the wrong table row.

// File: rtl/dram_qsel_pkg.sv
package dram_qsel_pkg;
  localparam int N_ACT   = 7;
  localparam int ACT_W   = 3;
  localparam int N_LVL_B = 2;
  localparam int N_CNT   = 3;
  localparam int ST_W    = N_LVL_B * N_CNT;
  localparam int N_ST    = 1 << ST_W;

  typedef enum logic [ACT_W-1:0] {
    CMD_ACT       = 3'd0,
    CMD_WR        = 3'd1,
    CMD_RD_LOAD   = 3'd2,
    CMD_RD_STORE  = 3'd3,
    CMD_PRE_PEND  = 3'd4,
    CMD_PRE_EARLY = 3'd5,
    CMD_NOP       = 3'd6
  } cmd_e;

  function automatic logic is_column(input logic [ACT_W-1:0] a);
    return (a == CMD_WR) || (a == CMD_RD_LOAD) || (a == CMD_RD_STORE);
  endfunction
endpackage

// File: rtl/dram_qsel_quant.sv
module dram_qsel_quant #(
  parameter int CNT_W   = 5,
  parameter int LO_MAX  = 3,
  parameter int MID_MAX = 7
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [1:0]       lvl
);
  localparam logic [CNT_W-1:0] LO_T  = CNT_W'(LO_MAX);
  localparam logic [CNT_W-1:0] MID_T = CNT_W'(MID_MAX);

  always_comb begin
    if (cnt == '0)          lvl = 2'd0;
    else if (cnt <= LO_T)   lvl = 2'd1;
    else if (cnt <= MID_T)  lvl = 2'd2;
    else                    lvl = 2'd3;
  end
endmodule

// File: rtl/dram_qsel_lfsr.sv
module dram_qsel_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [15:0] value
);
  logic [15:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (adv) lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  assign value = lfsr_q;
endmodule

// File: rtl/dram_qsel_pick.sv
module dram_qsel_pick
  import dram_qsel_pkg::*;
#(
  parameter int Q_W      = 16,
  parameter int EXP_BITS = 4
) (
  input  logic [N_ACT-1:0][Q_W-1:0] row,
  input  logic [N_ACT-1:0]          legal_mask,
  input  logic [15:0]               lfsr,
  output logic [ACT_W-1:0]          act,
  output logic                      explored
);
  localparam int START_W = 16 - EXP_BITS;

  logic [N_ACT-1:0]   legal_eff;
  logic [ACT_W-1:0]   greedy_a;
  logic [ACT_W-1:0]   rand_a;
  logic [START_W-1:0] start_raw;
  int                 start_i;

  always_comb begin
    legal_eff = legal_mask;
    legal_eff[CMD_NOP] = 1'b1;
  end

  // Greedy: strict greater-than keeps the lowest index on ties.
  always_comb begin
    logic found;
    logic signed [Q_W-1:0] best_v;
    found    = 1'b0;
    best_v   = '0;
    greedy_a = ACT_W'(CMD_NOP);
    for (int i = 0; i < N_ACT; i++) begin
      if (legal_eff[i] && (!found || ($signed(row[i]) > best_v))) begin
        found    = 1'b1;
        best_v   = $signed(row[i]);
        greedy_a = ACT_W'(i);
      end
    end
  end

  // Exploration: first legal command at or after a random start, wrapping.
  assign start_raw = lfsr[15:EXP_BITS];
  assign start_i   = int'(start_raw) % N_ACT;

  always_comb begin
    logic done;
    done   = 1'b0;
    rand_a = ACT_W'(CMD_NOP);
    for (int k = 0; k < N_ACT; k++) begin
      int idx;
      idx = (start_i + k) % N_ACT;
      if (!done && legal_eff[idx]) begin
        done   = 1'b1;
        rand_a = ACT_W'(idx);
      end
    end
  end

  assign explored = (lfsr[EXP_BITS-1:0] == '0);
  assign act      = explored ? rand_a : greedy_a;
endmodule

// File: rtl/dram_qsel_table.sv
module dram_qsel_table
  import dram_qsel_pkg::*;
#(
  parameter int Q_W      = 16,
  parameter int FRAC     = 8,
  parameter int ALPHA_SH = 2,
  parameter int GAMMA_SH = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step_en,
  input  logic [ST_W-1:0]           cur_s,
  input  logic [ACT_W-1:0]          cur_a,
  output logic [N_ACT-1:0][Q_W-1:0] cur_row,
  input  logic [ST_W-1:0]           peek_state,
  input  logic [ACT_W-1:0]          peek_act,
  output logic [Q_W-1:0]            peek_val
);
  localparam int X_W = Q_W + 2;
  localparam logic signed [X_W-1:0] REW   = X_W'(1 << FRAC);
  localparam logic signed [X_W-1:0] ZERO  = '0;
  localparam logic signed [X_W-1:0] Q_MAX = X_W'((1 << (Q_W - 1)) - 1);

  logic [Q_W-1:0]   tab_q [N_ST][N_ACT];
  logic [ST_W-1:0]  ps_q;
  logic [ACT_W-1:0] pa_q;
  logic             pr_q, have_q;

  logic [Q_W-1:0]          qc, qp, new_val;
  logic signed [X_W-1:0]   qc_x, qp_x, tgt, dlt, upd;
  logic                    wr_en;

  always_comb begin
    for (int i = 0; i < N_ACT; i++) cur_row[i] = tab_q[cur_s][i];
  end

  assign peek_val = (int'(peek_act) < N_ACT) ? tab_q[peek_state][peek_act] : '0;

  // Update arithmetic for the previous pair.
  assign qc   = tab_q[cur_s][cur_a];
  assign qp   = tab_q[ps_q][pa_q];
  assign qc_x = $signed({{2{qc[Q_W-1]}}, qc});
  assign qp_x = $signed({{2{qp[Q_W-1]}}, qp});
  assign tgt  = (pr_q ? REW : ZERO) + (qc_x >>> GAMMA_SH);
  assign dlt  = tgt - qp_x;
  assign upd  = qp_x + (dlt >>> ALPHA_SH);

  always_comb begin
    if (upd < ZERO)       new_val = '0;
    else if (upd > Q_MAX) new_val = Q_MAX[Q_W-1:0];
    else                  new_val = upd[Q_W-1:0];
  end

  assign wr_en = step_en && have_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N_ST; s++)
        for (int a = 0; a < N_ACT; a++)
          tab_q[s][a] <= '0;
    end else if (wr_en) begin
      tab_q[ps_q][pa_q] <= new_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      pa_q   <= '0;
      pr_q   <= 1'b0;
      have_q <= 1'b0;
    end else if (step_en) begin
      ps_q   <= cur_s;
      pa_q   <= cur_a;
      pr_q   <= is_column(cur_a);
      have_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dram_qsel.sv
module dram_qsel
  import dram_qsel_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int Q_W      = 16,
  parameter int FRAC     = 8,
  parameter int ALPHA_SH = 2,
  parameter int GAMMA_SH = 1,
  parameter int EXP_BITS = 4,
  parameter int LO_MAX   = 3,
  parameter int MID_MAX  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [CNT_W-1:0] lm_cnt,
  input  logic [6:0]       legal_mask,
  output logic [2:0]       act_o,
  output logic             explored_o,
  input  logic [5:0]       peek_state,
  input  logic [2:0]       peek_act,
  output logic [Q_W-1:0]   peek_val
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [N_CNT-1:0][1:0]       lvl_all;
  logic [ST_W-1:0]             cur_s;
  logic [N_ACT-1:0][Q_W-1:0]   cur_row;
  logic [15:0]                 lfsr_v;
  logic [ACT_W-1:0]            pick_a;
  logic                        pick_x;
  logic                        step_int;

  assign cnt_all  = {lm_cnt, wr_cnt, rd_cnt};
  assign step_int = step_en && rst_int_n;

  for (genvar g = 0; g < N_CNT; g++) begin : g_quant
    dram_qsel_quant #(.CNT_W(CNT_W), .LO_MAX(LO_MAX), .MID_MAX(MID_MAX)) u_q (
      .cnt (cnt_all[g]),
      .lvl (lvl_all[g])
    );
  end

  assign cur_s = {lvl_all[0], lvl_all[1], lvl_all[2]};

  dram_qsel_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .adv   (step_int),
    .value (lfsr_v)
  );

  dram_qsel_pick #(.Q_W(Q_W), .EXP_BITS(EXP_BITS)) u_pick (
    .row        (cur_row),
    .legal_mask (legal_mask),
    .lfsr       (lfsr_v),
    .act        (pick_a),
    .explored   (pick_x)
  );

  dram_qsel_table #(.Q_W(Q_W), .FRAC(FRAC), .ALPHA_SH(ALPHA_SH), .GAMMA_SH(GAMMA_SH)) u_tab (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .step_en    (step_int),
    .cur_s      (cur_s),
    .cur_a      (pick_a),
    .cur_row    (cur_row),
    .peek_state (peek_state),
    .peek_act   (peek_act),
    .peek_val   (peek_val)
  );

  assign act_o      = pick_a;
  assign explored_o = pick_x;
endmodule

// File: rtl/dram_qsel_chk.sv
module dram_qsel_chk #(
  parameter int Q_W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           step_en,
  input logic [6:0]     legal_mask,
  input logic [2:0]     act_o,
  input logic [5:0]     peek_state,
  input logic [2:0]     peek_act,
  input logic [Q_W-1:0] peek_val
);
  p_pick_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o == 3'd6) || (act_o < 3'd6 && legal_mask[act_o]));

  p_nop_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_mask[5:0] == 6'd0) |-> (act_o == 3'd6));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!step_en) && $stable(peek_state) && $stable(peek_act)) |-> $stable(peek_val));

  p_value_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_act < 3'd7) |-> !peek_val[Q_W-1]);

  p_bad_index_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_act == 3'd7) |-> (peek_val == '0));
endmodule

bind dram_qsel dram_qsel_chk #(.Q_W(Q_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .legal_mask (legal_mask),
  .act_o      (act_o),
  .peek_state (peek_state),
  .peek_act   (peek_act),
  .peek_val   (peek_val)
);

// File: tb/dram_qsel_tb.sv
module dram_qsel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_en = 1'b0;
  logic [4:0] rd_cnt = '0, wr_cnt = '0, lm_cnt = '0;
  logic [6:0] legal_mask = '0;
  logic [2:0] act_o;
  logic       explored_o;
  logic [5:0] peek_state = '0;
  logic [2:0] peek_act = '0;
  logic [15:0] peek_val;

  int total = 0, bad = 0;
  int tab [64][7];
  int lfsr;
  int ps, pa, pr, have;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_qsel u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .lm_cnt(lm_cnt),
    .legal_mask(legal_mask), .act_o(act_o), .explored_o(explored_o),
    .peek_state(peek_state), .peek_act(peek_act), .peek_val(peek_val)
  );

  function automatic int lvl(input int c);
    if (c == 0) return 0;
    if (c <= 3) return 1;
    if (c <= 7) return 2;
    return 3;
  endfunction

  function automatic int m_state();
    return lvl(rd_cnt) * 16 + lvl(wr_cnt) * 4 + lvl(lm_cnt);
  endfunction

  function automatic bit m_legal(input int a);
    return (a == 6) ? 1'b1 : legal_mask[a];
  endfunction

  function automatic bit m_explore();
    return (lfsr & 15) == 0;
  endfunction

  function automatic int m_pick();
    int s, best, st;
    s = m_state();
    if (m_explore()) begin
      st = (lfsr >> 4) % 7;
      for (int k = 0; k < 7; k++) if (m_legal((st + k) % 7)) return (st + k) % 7;
      return 6;
    end
    best = -1;
    for (int a = 0; a < 7; a++)
      if (m_legal(a) && (best < 0 || tab[s][a] > tab[s][best])) best = a;
    return best;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at cycle %0d", req, got, exp, cyc);
    end
  endtask

  // One step: drive at negedge, compare mid-cycle, advance model at posedge.
  task automatic step(input bit en, input int rc, input int wc, input int lc,
                      input int mask, input int ks, input int ka);
    int s, a, tag_a;
    string tag;
    @(negedge clk);
    step_en = en; rd_cnt = 5'(rc); wr_cnt = 5'(wc); lm_cnt = 5'(lc);
    legal_mask = 7'(mask); peek_state = 6'(ks); peek_act = 3'(ka);
    #2;
    s = m_state();
    a = m_pick();
    if (m_explore()) tag = "R7";
    else if ((mask & 63) == 0) tag = "R4";
    else tag = "R3";
    chk(tag, act_o, a);
    chk("R7 flag", explored_o, m_explore());
    chk(en ? "R9 peek" : "R8 peek", peek_val, tab[ks][ka]);
    tag_a = a;
    @(posedge clk);
    cyc++;
    if (en) begin
      if (have) begin
        int d;
        d = pr + (tab[s][tag_a] >>> 1) - tab[ps][pa];
        tab[ps][pa] = tab[ps][pa] + (d >>> 2);
      end
      ps = s; pa = tag_a; pr = (tag_a >= 1 && tag_a <= 3) ? 256 : 0; have = 1;
      lfsr = ((lfsr << 1) & 16'hFFFF) |
             (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bands[7];
    bands = '{0, 1, 3, 4, 7, 8, 31};
    for (int s = 0; s < 64; s++) for (int a = 0; a < 7; a++) tab[s][a] = 0;
    lfsr = 16'hACE1; have = 0; ps = 0; pa = 0; pr = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: every entry zero after reset
    for (int s = 0; s < 64; s++)
      for (int a = 0; a < 7; a++) begin
        @(negedge clk); peek_state = 6'(s); peek_act = 3'(a); #2;
        chk("R1 reset", peek_val, 0);
      end

    // R5 / R2: write-only legal, counts on band edges -> state 27
    step(1, 3, 4, 8, 7'h02, 27, 1);
    step(1, 3, 4, 8, 7'h02, 27, 1);
    step(0, 3, 4, 8, 7'h02, 27, 1);
    chk("R5 reward", peek_val, tab[27][1]);
    chk("R2 state", (tab[27][1] != 0) ? 1 : 0, 1);

    // R4: nothing but NOP legal, including mask[6] cleared
    for (int i = 0; i < 20; i++) step(1, i % 32, (i * 3) % 32, (i * 7) % 32, 7'h00, 0, 6);
    for (int i = 0; i < 20; i++) step(1, 2, 2, 2, 7'h40, 21, 6);

    // R2: walk band edges with all commands legal
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++)
        step(1, bands[i], bands[j], bands[(i + j) % 7], 7'h7F,
             lvl(bands[i]) * 16 + lvl(bands[j]) * 4 + lvl(bands[(i + j) % 7]), j);

    // R6: repeat the same pair so update reads its own old value
    for (int i = 0; i < 40; i++) step(1, 5, 0, 0, 7'h04, 32, 2);

    // R3/R6/R7/R8: random stimulus with idle gaps
    for (int i = 0; i < 6000; i++)
      step(($urandom % 4) != 0, $urandom % 32, $urandom % 32, $urandom % 32,
           $urandom % 128, $urandom % 64, $urandom % 7);

    // R8: long idle stretch, values and LFSR frozen
    for (int i = 0; i < 30; i++) step(0, 9, 9, 9, 7'h7F, i, i % 7);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule